// File: doc/BRIEF.md
# Interrupt Event-State Coalescing Source

This block keeps a two-bit event state for each of `NUM_SRC` interrupt sources and decides, on every trigger and every end-of-interrupt, whether the event must be forwarded to a downstream router. The state holds a "pending" flag (P, bit 1) and a "re-triggered while pending" flag (Q, bit 0). Coalescing through these two bits guarantees that each source has at most one notification outstanding. Software drives the state through 8-byte loads and stores whose address picks the source and whose low 12 bits pick the command. Per-source input lines also trigger sources, on their rising edge.

The access address is split at `PAGE_SHIFT`. The bits above it form the source index, and the low 12 bits form the command offset. A shift of 13 or 17 selects the split layout. In that layout the lower half of each source's window is a trigger-only page and the upper half is the management page. A shift of 12 or 16 puts both roles on one page. Each access is applied as one atomic read-modify-write.

A notification leaves on a valid/ready channel that carries the source index. While a notification waits, the block accepts no new command.

Control is a two-state machine:
- `ST_IDLE` accepts commands. The transition `IDLE->NOTIFY` is taken when the applied command forwards an event.
- `ST_NOTIFY` holds the notification. The transition `NOTIFY->IDLE` is taken when the consumer asserts ready.

Top module: `evc_coalesce_src`

## Requirements
- R1: After reset every source's state is 01 (off), so a state read of any source returns 1.
- R2: A trigger moves 00 to 10 and forwards a notification. It moves 10 and 11 to 11, and keeps 01 at 01, without a notification.
- R3: An EOI moves 11 to 10 and forwards a notification. It moves 00 and 10 to 00, and keeps 01 at 01, without a notification.
- R4: A load on the management page at offset 0x000-0x7FF performs an EOI and returns 1 if it forwarded a notification, else 0. A load produces `rsp_valid` one cycle after acceptance; a store never does.
- R5: A load at offset 0x800-0xBFF returns the current state (P in bit 1, Q in bit 0) and leaves it unchanged.
- R6: A load at offset 0xC00-0xFFF returns the old state and sets the state to offset bits [9:8]. A store at 0xC00-0xFFF on the management page sets the state the same way and returns nothing.
- R7: In the split layout, address bit `PAGE_SHIFT-1` = 0 selects the trigger page. A load there returns all ones, pulses `err_pulse` and changes no state. A store there at any offset is a trigger.
- R8: On the management page a store at 0x000-0x3FF is a trigger. A store at 0x800-0xBFF changes no state and pulses `err_pulse`.
- R9: A store at 0x400-0x7FF performs an EOI only while `store_eoi_en` is 1. Otherwise it changes no state, forwards nothing and pulses `err_pulse`.
- R10: In the single-page layout, loads follow management-page rules and stores at 0x000-0x3FF trigger.
- R11: An access with `req_bytes` other than 8 changes no state and pulses `err_pulse`. A load of this kind returns all ones.
- R12: A rising edge on `line_in[i]` triggers source i. When a command is accepted in the same cycle, the command is applied first and the line trigger follows.
- R13: `ntf_valid` and `ntf_src` hold steady until `ntf_ready`, and `req_ready` stays low while `ntf_valid` is high.
- R14: The source index is the address shifted right by `PAGE_SHIFT`, and the notification carries that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_eoi_en | input | 1 | Enables EOI by store at offset 0x400-0x7FF |
| line_in | input | NUM_SRC | Per-source trigger lines, rising-edge sensitive |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Command accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+SRC_W | Access address |
| req_bytes | input | 4 | Access size in bytes; only 8 is legal |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Load data, value in bits [63:0] |
| ntf_valid | output | 1 | Notification valid |
| ntf_ready | input | 1 | Notification accepted |
| ntf_src | output | SRC_W | Index of the notified source |
| err_pulse | output | 1 | One-cycle strobe for an invalid access |

## Verification
The assertions assume that `ntf_ready` may be driven freely, and that a requester keeps its command stable only while `req_ready` is high. The response and stall properties therefore depend on the acceptance handshake alone. The bench starts every command from `ST_IDLE` with the notification channel drained. The one exception is a backpressure scenario that holds `ntf_ready` low on purpose. Inputs change only on the falling edge, and all line pulses last several cycles, so every rising edge is seen.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_EOI,
        OP_GET,
        OP_SET
    } evc_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_NOTIFY
    } evc_state_e;

    localparam logic [1:0] PQ_IDLE = 2'b00;
    localparam logic [1:0] PQ_OFF  = 2'b01;
    localparam logic [1:0] PQ_PEND = 2'b10;
    localparam logic [1:0] PQ_REQD = 2'b11;
endpackage

// File: rtl/evc_decode.sv
`timescale 1ns/1ps
module evc_decode
    import evc_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 17,
    parameter int SRC_W      = 3,
    parameter int ADDR_W     = PAGE_SHIFT + SRC_W
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        nbytes,
    input  logic              eoi_store_en,
    output evc_op_e           op,
    output logic [1:0]        set_pq,
    output logic [SRC_W-1:0]  src,
    output logic              bad,
    output logic              ones
);
    localparam bit SPLIT = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

    logic [11:0] off;
    logic        on_trig;
    logic        unused_addr;

    assign off         = addr[11:0];
    assign src         = addr[ADDR_W-1:PAGE_SHIFT];
    assign on_trig     = SPLIT ? !addr[PAGE_SHIFT-1] : 1'b0;
    assign unused_addr = ^addr;
    assign set_pq      = off[9:8];

    always_comb begin
        op   = OP_NONE;
        bad  = 1'b0;
        ones = 1'b0;
        if (nbytes != 4'd8 || int'(src) >= NUM_SRC) begin
            bad  = 1'b1;
            ones = !is_write;
        end else if (!is_write) begin
            if (on_trig) begin
                bad  = 1'b1;
                ones = 1'b1;
            end else begin
                unique case (off[11:10])
                    2'b00, 2'b01: op = OP_EOI;
                    2'b10:        op = OP_GET;
                    default:      op = OP_SET;
                endcase
            end
        end else if (on_trig) begin
            op = OP_TRIG;
        end else begin
            unique case (off[11:10])
                2'b00:   op = OP_TRIG;
                2'b01: begin
                    if (eoi_store_en) op = OP_EOI;
                    else              bad = 1'b1;
                end
                2'b10:   bad = 1'b1;
                default: op = OP_SET;
            endcase
        end
    end
endmodule

// File: rtl/evc_pq_step.sv
`timescale 1ns/1ps
module evc_pq_step
    import evc_pkg::*;
(
    input  evc_op_e    op,
    input  logic [1:0] cur,
    input  logic [1:0] set_pq,
    output logic [1:0] nxt,
    output logic       fwd
);
    always_comb begin
        nxt = cur;
        fwd = 1'b0;
        unique case (op)
            OP_TRIG: begin
                unique case (cur)
                    PQ_IDLE: begin nxt = PQ_PEND; fwd = 1'b1; end
                    PQ_OFF:  nxt = PQ_OFF;
                    default: nxt = PQ_REQD;
                endcase
            end
            OP_EOI: begin
                unique case (cur)
                    PQ_REQD: begin nxt = PQ_PEND; fwd = 1'b1; end
                    PQ_OFF:  nxt = PQ_OFF;
                    default: nxt = PQ_IDLE;
                endcase
            end
            OP_SET:  nxt = set_pq;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/evc_line_arb.sv
`timescale 1ns/1ps
module evc_line_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               take,
    output logic               has_req,
    output logic [SRC_W-1:0]   pick
);
    logic [NUM_SRC-1:0] line_d;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = SRC_W'(i);
        end
        clr = '0;
        if (take) clr[pick] = 1'b1;
    end

    assign has_req = |pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_d <= '0;
            pend_q <= '0;
        end else begin
            line_d <= line_in;
            pend_q <= (pend_q & ~clr) | (line_in & ~line_d);
        end
    end
endmodule

// File: rtl/evc_coalesce_src.sv
`timescale 1ns/1ps
module evc_coalesce_src
    import evc_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 17,
    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W    = PAGE_SHIFT + SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_eoi_en,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [3:0]         req_bytes,
    output logic               rsp_valid,
    output logic [63:0]        rsp_data,
    output logic               ntf_valid,
    input  logic               ntf_ready,
    output logic [SRC_W-1:0]   ntf_src,
    output logic               err_pulse
);
    evc_state_e         state_q, state_nx;
    logic [1:0]         pq_q [NUM_SRC];
    logic [2*NUM_SRC-1:0] pq_flat;

    evc_op_e            dec_op, cur_op;
    logic [1:0]         dec_set;
    logic [SRC_W-1:0]   dec_src, cur_src, line_pick;
    logic               dec_bad, dec_ones;
    logic               line_has, mmio_go, line_go;
    logic [1:0]         cur_pq, nxt_pq;
    logic               fwd;

    evc_decode #(
        .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
    ) u_dec (
        .is_write(req_write), .addr(req_addr), .nbytes(req_bytes),
        .eoi_store_en(store_eoi_en), .op(dec_op), .set_pq(dec_set),
        .src(dec_src), .bad(dec_bad), .ones(dec_ones)
    );

    evc_line_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .take(line_go),
        .has_req(line_has), .pick(line_pick)
    );

    evc_pq_step u_step (
        .op(cur_op), .cur(cur_pq), .set_pq(dec_set), .nxt(nxt_pq), .fwd(fwd)
    );

    // Command selection: a bus command wins over a queued line trigger.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mmio_go   = req_valid && req_ready;
        line_go   = (state_q == ST_IDLE) && !req_valid && line_has;
        cur_src   = mmio_go ? dec_src : line_pick;
        cur_op    = mmio_go ? dec_op : (line_go ? OP_TRIG : OP_NONE);
        cur_pq    = pq_q[cur_src];
        ntf_valid = (state_q == ST_NOTIFY);
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (fwd)       state_nx = ST_NOTIFY;
            ST_NOTIFY: if (ntf_ready) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            err_pulse <= 1'b0;
            ntf_src   <= '0;
        end else begin
            rsp_valid <= mmio_go && !req_write;
            err_pulse <= mmio_go && dec_bad;
            if (mmio_go && !req_write) begin
                if (dec_ones)              rsp_data <= '1;
                else if (dec_op == OP_EOI) rsp_data <= {63'd0, fwd};
                else                       rsp_data <= {62'd0, cur_pq};
            end
            if (fwd) ntf_src <= cur_src;
        end
    end

    // Event state array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) pq_q[i] <= PQ_OFF;
        end else if (cur_op != OP_NONE) begin
            pq_q[cur_src] <= nxt_pq;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) pq_flat[2*i +: 2] = pq_q[i];
    end
endmodule

// File: rtl/evc_coalesce_src_chk.sv
`timescale 1ns/1ps
module evc_coalesce_src_chk #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic                 ntf_valid,
    input logic                 ntf_ready,
    input logic [SRC_W-1:0]     ntf_src,
    input logic [2*NUM_SRC-1:0] pq_flat
);
    logic first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (pq_flat == {NUM_SRC{2'b01}}));

    assert_load_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && !req_write) |=> !rsp_valid);

    assert_ntf_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_src)));

    assert_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> !req_ready);

    assert_ntf_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ntf_valid && ntf_ready) |=> !ntf_valid);
endmodule

bind evc_coalesce_src evc_coalesce_src_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .ntf_valid(ntf_valid),
    .ntf_ready(ntf_ready), .ntf_src(ntf_src), .pq_flat(pq_flat)
);

// File: tb/evc_coalesce_src_tb.sv
`timescale 1ns/1ps
module evc_coalesce_src_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoi_en = 1'b0;
    logic [7:0]  m_line = '0;
    logic        b_valid = 1'b0, b_wr = 1'b0, b_sel = 1'b0;
    logic [19:0] b_addr = '0;
    logic [3:0]  b_bytes = 4'd8;
    logic        ntf_rdy = 1'b1;

    logic        m_ready, m_rsp_v, m_ntf_v, m_err;
    logic [63:0] m_rsp;
    logic [2:0]  m_ntf_src;
    logic        o_ready, o_rsp_v, o_ntf_v, o_err;
    logic [63:0] o_rsp;
    logic [1:0]  o_ntf_src;

    int errors = 0, checks = 0;
    int m_cnt = 0, o_cnt = 0;
    int m_log [32];
    int o_last = -1;
    bit done = 0;

    always #2.5 clk = ~clk;

    evc_coalesce_src #(.NUM_SRC(8), .PAGE_SHIFT(17)) u_dut (
        .clk(clk), .rst_n(rst_n), .store_eoi_en(eoi_en), .line_in(m_line),
        .req_valid(b_valid && !b_sel), .req_ready(m_ready), .req_write(b_wr),
        .req_addr(b_addr), .req_bytes(b_bytes), .rsp_valid(m_rsp_v),
        .rsp_data(m_rsp), .ntf_valid(m_ntf_v), .ntf_ready(ntf_rdy),
        .ntf_src(m_ntf_src), .err_pulse(m_err)
    );

    evc_coalesce_src #(.NUM_SRC(4), .PAGE_SHIFT(12)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .store_eoi_en(1'b0), .line_in(4'd0),
        .req_valid(b_valid && b_sel), .req_ready(o_ready), .req_write(b_wr),
        .req_addr(b_addr[13:0]), .req_bytes(b_bytes), .rsp_valid(o_rsp_v),
        .rsp_data(o_rsp), .ntf_valid(o_ntf_v), .ntf_ready(1'b1),
        .ntf_src(o_ntf_src), .err_pulse(o_err)
    );

    always @(negedge clk) begin
        if (m_ntf_v && ntf_rdy) begin
            if (m_cnt < 32) m_log[m_cnt] = int'(m_ntf_src);
            m_cnt++;
        end
        if (o_ntf_v) begin
            o_cnt++;
            o_last = int'(o_ntf_src);
        end
    end

    function automatic logic [19:0] mga(int s, int off);
        return 20'((s << 17) | (1 << 16) | off);
    endfunction
    function automatic logic [19:0] tga(int s, int off);
        return 20'((s << 17) | off);
    endfunction
    function automatic logic [19:0] opa(int s, int off);
        return 20'((s << 12) | off);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one access from a falling edge; ends on a falling edge with the block idle.
    task automatic acc(bit sel, bit wr, logic [19:0] a, logic [3:0] nb,
                       output logic [63:0] d, output logic e);
        b_sel = sel; b_wr = wr; b_addr = a; b_bytes = nb; b_valid = 1'b1;
        @(negedge clk);
        b_valid = 1'b0;
        d = sel ? o_rsp : m_rsp;
        e = sel ? o_err : m_err;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ld(bit sel, logic [19:0] a, output logic [63:0] d);
        logic e;
        acc(sel, 1'b0, a, 4'd8, d, e);
    endtask

    task automatic st(bit sel, logic [19:0] a);
        logic [63:0] d;
        logic e;
        acc(sel, 1'b1, a, 4'd8, d, e);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        for (int s = 0; s < 8; s++) begin
            ld(0, mga(s, 'h800), d);
            chk("R1 reset state off", d, 64'd1);
        end
    endtask

    task automatic t_trigger;
        logic [63:0] d;
        int n0;
        ld(0, mga(0, 'hC00), d);
        chk("R6 set-load returns old", d, 64'd1);
        n0 = m_cnt;
        st(0, mga(0, 'h000));
        chk("R2 00 trigger notifies", 64'(m_cnt - n0), 64'd1);
        chk("R14 notify index", 64'(m_log[n0]), 64'd0);
        ld(0, mga(0, 'h800), d);
        chk("R5 state 10 after trigger", d, 64'd2);
        st(0, mga(0, 'h100));
        ld(0, mga(0, 'h900), d);
        chk("R2 10 trigger to 11", d, 64'd3);
        st(0, mga(0, 'h3F8));
        ld(0, mga(0, 'h800), d);
        chk("R2 11 stays 11", d, 64'd3);
        chk("R2 no extra notify", 64'(m_cnt - n0), 64'd1);
        ld(0, mga(0, 'hD00), d);
        chk("R6 set 01 returns old", d, 64'd3);
        st(0, mga(0, 'h000));
        ld(0, mga(0, 'h800), d);
        chk("R2 off ignores trigger", d, 64'd1);
        chk("R2 off no notify", 64'(m_cnt - n0), 64'd1);
    endtask

    task automatic t_eoi;
        logic [63:0] d;
        int n0;
        n0 = m_cnt;
        ld(0, mga(1, 'hC00), d);
        ld(0, mga(1, 'h000), d);
        chk("R4 EOI on 00 returns 0", d, 64'd0);
        ld(0, mga(1, 'hE00), d);
        ld(0, mga(1, 'h010), d);
        chk("R4 EOI on 10 returns 0", d, 64'd0);
        ld(0, mga(1, 'h800), d);
        chk("R3 10 to 00", d, 64'd0);
        ld(0, mga(1, 'hF00), d);
        ld(0, mga(1, 'h400), d);
        chk("R4 EOI on 11 returns 1", d, 64'd1);
        chk("R3 11 renotifies", 64'(m_cnt - n0), 64'd1);
        chk("R14 EOI notify index", 64'(m_log[n0]), 64'd1);
        ld(0, mga(1, 'h800), d);
        chk("R3 11 to 10", d, 64'd2);
        ld(0, mga(1, 'hD00), d);
        ld(0, mga(1, 'h000), d);
        chk("R3 off EOI returns 0", d, 64'd0);
        ld(0, mga(1, 'h800), d);
        chk("R3 off stays off", d, 64'd1);
    endtask

    task automatic t_trig_page;
        logic [63:0] d;
        logic e;
        int n0;
        ld(0, mga(2, 'hC00), d);
        acc(0, 1'b0, tga(2, 'h800), 4'd8, d, e);
        chk("R7 trigger-page load all ones", d, {64{1'b1}});
        chk("R7 trigger-page load error", 64'(e), 64'd1);
        ld(0, mga(2, 'h800), d);
        chk("R7 trigger-page load no change", d, 64'd0);
        n0 = m_cnt;
        st(0, tga(2, 'h800));
        ld(0, mga(2, 'h800), d);
        chk("R7 trigger-page store triggers", d, 64'd2);
        chk("R7 trigger-page store notifies src2", 64'(m_log[n0]), 64'd2);
    endtask

    task automatic t_mgmt_store;
        logic [63:0] d;
        logic e;
        st(0, mga(3, 'hF00));
        ld(0, mga(3, 'h800), d);
        chk("R6 store sets 11", d, 64'd3);
        acc(0, 1'b1, mga(3, 'h800), 4'd8, d, e);
        chk("R8 store 0x800 error", 64'(e), 64'd1);
        ld(0, mga(3, 'h800), d);
        chk("R8 store 0x800 no change", d, 64'd3);
    endtask

    task automatic t_store_eoi;
        logic [63:0] d;
        logic e;
        int n0;
        n0 = m_cnt;
        eoi_en = 1'b0;
        acc(0, 1'b1, mga(3, 'h400), 4'd8, d, e);
        chk("R9 disabled store-EOI error", 64'(e), 64'd1);
        ld(0, mga(3, 'h800), d);
        chk("R9 disabled store-EOI no change", d, 64'd3);
        chk("R9 disabled no notify", 64'(m_cnt - n0), 64'd0);
        eoi_en = 1'b1;
        st(0, mga(3, 'h7F8));
        ld(0, mga(3, 'h800), d);
        chk("R9 enabled store-EOI 11 to 10", d, 64'd2);
        chk("R9 enabled notifies src3", 64'(m_log[n0]), 64'd3);
        eoi_en = 1'b0;
    endtask

    task automatic t_size;
        logic [63:0] d;
        logic e;
        acc(0, 1'b0, mga(3, 'hC00), 4'd4, d, e);
        chk("R11 short load all ones", d, {64{1'b1}});
        chk("R11 short load error", 64'(e), 64'd1);
        acc(0, 1'b1, mga(3, 'hC00), 4'd2, d, e);
        chk("R11 short store error", 64'(e), 64'd1);
        ld(0, mga(3, 'h800), d);
        chk("R11 short accesses no change", d, 64'd2);
    endtask

    task automatic t_line;
        logic [63:0] d;
        int n0;
        ld(0, mga(4, 'hC00), d);
        n0 = m_cnt;
        m_line[4] = 1'b1;
        repeat (4) @(negedge clk);
        m_line[4] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 line trigger notifies src4", 64'(m_log[n0]), 64'd4);
        ld(0, mga(4, 'h800), d);
        chk("R12 line trigger state 10", d, 64'd2);
        ld(0, mga(5, 'hC00), d);
        ld(0, mga(6, 'hC00), d);
        n0 = m_cnt;
        m_line[5] = 1'b1;
        st(0, mga(6, 'h000));
        repeat (4) @(negedge clk);
        m_line[5] = 1'b0;
        chk("R12 bus command served first", 64'(m_log[n0]), 64'd6);
        chk("R12 line trigger follows", 64'(m_log[n0 + 1]), 64'd5);
    endtask

    task automatic t_backpressure;
        logic [63:0] d;
        ld(0, mga(7, 'hC00), d);
        ntf_rdy = 1'b0;
        b_sel = 0; b_wr = 1'b1; b_addr = mga(7, 'h000); b_bytes = 4'd8; b_valid = 1'b1;
        @(negedge clk);
        b_valid = 1'b0;
        repeat (3) begin
            chk("R13 notify held", 64'(m_ntf_v), 64'd1);
            chk("R13 notify index held", 64'(m_ntf_src), 64'd7);
            chk("R13 commands stalled", 64'(m_ready), 64'd0);
            @(negedge clk);
        end
        #1 ntf_rdy = 1'b1;
        @(negedge clk);
        chk("R13 notify released", 64'(m_ntf_v), 64'd0);
        chk("R13 commands resume", 64'(m_ready), 64'd1);
    endtask

    task automatic t_one_page;
        logic [63:0] d;
        logic e;
        int n0;
        ld(1, opa(2, 'hC00), d);
        chk("R10 one-page set-load returns old", d, 64'd1);
        n0 = o_cnt;
        st(1, opa(2, 'h000));
        chk("R10 one-page store triggers", 64'(o_cnt - n0), 64'd1);
        chk("R14 one-page index", 64'(o_last), 64'd2);
        ld(1, opa(2, 'h800), d);
        chk("R10 one-page state 10", d, 64'd2);
        ld(1, opa(2, 'h000), d);
        chk("R10 one-page load is EOI", d, 64'd0);
        ld(1, opa(2, 'h800), d);
        chk("R10 one-page EOI to 00", d, 64'd0);
        ld(1, opa(1, 'h800), d);
        chk("R14 one-page other source off", d, 64'd1);
        acc(1, 1'b1, opa(2, 'h900), 4'd8, d, e);
        chk("R10 one-page store 0x900 error", 64'(e), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'(m_ready), 64'd1);
        t_reset();
        t_trigger();
        t_eoi();
        t_trig_page();
        t_mgmt_store();
        t_store_eoi();
        t_size();
        t_line();
        t_backpressure();
        t_one_page();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule